// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block handles inbound message-signalled interrupts at a PCIe root port. It watches the memory writes arriving from the link. Each write carries a 64-bit address, 32-bit data and a valid strobe. There are eight vector groups. Each group has its own programmable 64-bit capture address. When a write lands on the capture address of an enabled group, the low five bits of the write data pick one of the group's 32 vectors, and that vector's status bit is latched.

Each group holds its status bits and a per-vector enable mask. A group becomes pending while any enabled vector has its status set. Masking a vector hides it but keeps its status. Each pending group sets its own bit in a top-level summary register. Software clears those bits by writing ones to them. The summary register is gated by a top-level enable. The result drives one registered, level-sensitive interrupt line to the host.

Software reaches every register through a plain 32-bit register port. The port has a write strobe and returns read data one cycle after the address is presented.

Top module: `msi_agg_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Group g has a capture address. Its low word is at 0xC00 + 0x10*g and its high word is at 0xC80 + 4*g. Both are read/write.
- R3: A write hits group g when `in_valid` is high, group g is enabled and `in_addr` equals that group's capture address. A hit sets status bit `in_data[4:0]` of the group. Data values 32 apart select the same vector. The status register is at 0xC04 + 0x10*g and bit v is vector v.
- R4: The group-enable register is at 0x190, with bit g for group g. A write to the capture address of a group whose bit is clear changes nothing. A write that matches no capture address changes nothing.
- R5: A status register clears bit by bit when ones are written to it. If a capture and such a clear hit the same bit in the same cycle, the bit ends up set.
- R6: The per-vector enable register is at 0xC08 + 0x10*g. Group g is pending when its status ANDed with its enable is nonzero. A masked vector keeps its status bit.
- R7: The summary register is at 0x184, with bit 8+g for group g. The bit is set one cycle after any cycle in which the group is pending. Writing one to the bit clears it. If the group is still pending, the bit stays set.
- R8: The top-level enable register is at 0x180, with bit 8+g for group g. `irq_o` equals the OR of (summary AND top-level enable) from the previous cycle.
- R9: Only bits 8 to 15 of 0x180 and 0x184 are implemented. Bits 24 to 27 and every other bit read zero.
- R10: Read data appears on `reg_rdata` one clock after `reg_addr` is presented. Any offset not listed above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound memory write strobe |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The main sweep sends a capture to every vector of every group. The data values include ones offset by 32 and 64, so it shows whether the vector is decoded from the low data bits only. It also shows whether each group's status and summary bit stay separate from every other group's. Separate patterns cover the cases where a capture should do nothing: a write to a disabled group, and a write whose high address word matches no capture address. These patterns separate correct address and enable gating from captures that leak through. Same-cycle collisions show whether set takes priority over clear: a capture against a status clear, and a summary clear while the group is still pending. A mask-then-unmask sequence and an enable toggle show that status survives masking and that the interrupt follows the enable one cycle later.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFS_TOP_EN   = 12'h180;
  localparam logic [REG_AW-1:0] OFS_TOP_STAT = 12'h184;
  localparam logic [REG_AW-1:0] OFS_GRP_EN   = 12'h190;
  localparam logic [REG_AW-1:0] OFS_GRP_BASE = 12'hC00;
  localparam logic [REG_AW-1:0] OFS_HI_BASE  = 12'hC80;
  localparam int GRP_STRIDE = 16;
  localparam int HI_STRIDE  = 4;
  localparam logic [REG_AW-1:0] SUB_STAT = 12'h004;
  localparam logic [REG_AW-1:0] SUB_VEN  = 12'h008;
  localparam int TOP_SHIFT = 8;
endpackage

// File: rtl/msi_grp_unit.sv
module msi_grp_unit
  import msi_agg_pkg::*;
#(
  parameter int GRP_IDX     = 0,
  parameter int VEC_PER_GRP = 32,
  localparam int IDX_W      = $clog2(VEC_PER_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_on,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [IDX_W-1:0]  in_vec,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] rd_data,
  output logic              pending
);
  localparam logic [REG_AW-1:0] A_LO   = OFS_GRP_BASE + REG_AW'(GRP_IDX * GRP_STRIDE);
  localparam logic [REG_AW-1:0] A_STAT = A_LO + SUB_STAT;
  localparam logic [REG_AW-1:0] A_VEN  = A_LO + SUB_VEN;
  localparam logic [REG_AW-1:0] A_HI   = OFS_HI_BASE + REG_AW'(GRP_IDX * HI_STRIDE);

  logic [31:0]            cap_lo, cap_hi;
  logic [VEC_PER_GRP-1:0] stat, ven, set_mask, clr_mask;
  logic                   hit;

  assign hit      = in_valid && grp_on && (in_addr == {cap_hi, cap_lo});
  assign set_mask = hit ? (VEC_PER_GRP'(1) << in_vec) : '0;
  assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata[VEC_PER_GRP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo <= '0;
      cap_hi <= '0;
      ven    <= '0;
      stat   <= '0;
    end else begin
      if (reg_we && reg_addr == A_LO) cap_lo <= reg_wdata;
      if (reg_we && reg_addr == A_HI) cap_hi <= reg_wdata;
      if (reg_we && reg_addr == A_VEN) ven <= reg_wdata[VEC_PER_GRP-1:0];
      stat <= (stat & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == A_LO)   rd_data = cap_lo;
    if (reg_addr == A_HI)   rd_data = cap_hi;
    if (reg_addr == A_STAT) rd_data = REG_DW'(stat);
    if (reg_addr == A_VEN)  rd_data = REG_DW'(ven);
  end

  assign pending = |(stat & ven);
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_agg_pkg::*;
#(
  parameter int NUM_GRPS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  input  logic [NUM_GRPS-1:0] grp_pend,
  output logic [NUM_GRPS-1:0] grp_en,
  output logic [NUM_GRPS-1:0] top_en,
  output logic [NUM_GRPS-1:0] top_stat,
  output logic [REG_DW-1:0]   rd_data,
  output logic                irq_o
);
  logic [NUM_GRPS-1:0] top_clr;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign top_clr = (reg_we && reg_addr == OFS_TOP_STAT) ?
                   reg_wdata[TOP_SHIFT +: NUM_GRPS] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_en   <= '0;
      top_en   <= '0;
      top_stat <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_GRP_EN) grp_en <= reg_wdata[NUM_GRPS-1:0];
      if (reg_we && reg_addr == OFS_TOP_EN) top_en <= reg_wdata[TOP_SHIFT +: NUM_GRPS];
      top_stat <= (top_stat & ~top_clr) | grp_pend;
      irq_o    <= |(top_stat & top_en);
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == OFS_GRP_EN)   rd_data = REG_DW'(grp_en);
    if (reg_addr == OFS_TOP_EN)   rd_data = REG_DW'(top_en) << TOP_SHIFT;
    if (reg_addr == OFS_TOP_STAT) rd_data = REG_DW'(top_stat) << TOP_SHIFT;
  end
endmodule

// File: rtl/msi_agg_top.sv
module msi_agg_top
  import msi_agg_pkg::*;
#(
  parameter int NUM_GRPS    = 8,
  parameter int VEC_PER_GRP = 32,
  localparam int IDX_W      = $clog2(VEC_PER_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [31:0]       in_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NUM_GRPS-1:0] grp_pend, grp_en, top_en, top_stat;
  logic [REG_DW-1:0]   unit_rd [NUM_GRPS];
  logic [REG_DW-1:0]   ctrl_rd, rd_any;
  logic                unused_data_hi;

  assign unused_data_hi = ^in_data[31:IDX_W];

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    msi_grp_unit #(.GRP_IDX(g), .VEC_PER_GRP(VEC_PER_GRP)) i_grp (
      .clk      (clk),
      .rst      (rst),
      .grp_on   (grp_en[g]),
      .in_valid (in_valid),
      .in_addr  (in_addr),
      .in_vec   (in_data[IDX_W-1:0]),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .rd_data  (unit_rd[g]),
      .pending  (grp_pend[g])
    );
  end

  msi_irq_ctrl #(.NUM_GRPS(NUM_GRPS)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .grp_pend (grp_pend),
    .grp_en   (grp_en),
    .top_en   (top_en),
    .top_stat (top_stat),
    .rd_data  (ctrl_rd),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_any = ctrl_rd;
    for (int g = 0; g < NUM_GRPS; g++) rd_any = rd_any | unit_rd[g];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_any;
  end
endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk #(
  parameter int NUM_GRPS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                irq_o,
  input logic [NUM_GRPS-1:0] grp_pend,
  input logic [NUM_GRPS-1:0] top_en,
  input logic [NUM_GRPS-1:0] top_stat
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (top_stat == '0 && !irq_o && top_en == '0)); // R1

  AST_PEND_SETS_TOP: assert property (@(posedge clk) disable iff (rst)
    (grp_pend != '0) |=> ((top_stat & $past(grp_pend)) == $past(grp_pend))); // R7

  AST_TOP_RISE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    ((top_stat & ~$past(top_stat) & ~$past(grp_pend)) == '0)); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((top_stat & top_en) != '0) |=> irq_o); // R8

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    ((top_stat & top_en) == '0) |=> !irq_o); // R8
endmodule

bind msi_agg_top msi_agg_chk #(.NUM_GRPS(NUM_GRPS)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_o   (irq_o),
  .grp_pend(grp_pend),
  .top_en  (top_en),
  .top_stat(top_stat)
);

// File: tb/test_msi_agg_top.sv
module test_msi_agg_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int NV = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_agg_top i_msi_agg_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] lo_of(int g); return 32'hFEE0_0000 + 32'(g * 64); endfunction
  function automatic logic [31:0] hi_of(int g); return 32'h0000_0001 + 32'(g); endfunction
  function automatic logic [11:0] stat_of(int g); return 12'hC04 + 12'(g * 16); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic cap(logic [63:0] a, logic [31:0] d);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    check("R1 irq", 32'(irq_o), 0);
    rd(12'h180, v); check("R1 top_en", v, 0);
    rd(12'h190, v); check("R1 grp_en", v, 0);
    rd(12'hC00, v); check("R1 lo", v, 0);
    rd(12'hC84, v); check("R1 hi", v, 0);

    // R2: capture addresses per group
    for (int g = 0; g < NG; g++) begin
      wr(12'hC00 + 12'(g * 16), lo_of(g));
      wr(12'hC80 + 12'(g * 4), hi_of(g));
      wr(12'hC08 + 12'(g * 16), 32'hFFFF_FFFF);
    end
    for (int g = 0; g < NG; g++) begin
      rd(12'hC00 + 12'(g * 16), v); check("R2 lo", v, lo_of(g));
      rd(12'hC80 + 12'(g * 4), v);  check("R2 hi", v, hi_of(g));
    end

    // R4: group disabled -> capture ignored
    cap({hi_of(0), lo_of(0)}, 32'd4);
    rd(stat_of(0), v); check("R4 disabled", v, 0);

    // R9: only bits 8..15 of top enable implemented
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, v); check("R9 top_en bits", v, 32'h0000_FF00);
    wr(12'h190, 32'h0000_00FF);
    rd(12'h190, v); check("R4 grp_en", v, 32'h0000_00FF);

    // R3/R5/R7/R8 sweep over all groups and vectors
    for (int g = 0; g < NG; g++) begin
      for (int k = 0; k < NV; k++) begin
        cap({hi_of(g), lo_of(g)}, 32'(k + 32 * (k % 3)));
        rd(stat_of(g), v);   check("R3 status", v, 32'(1) << k);
        rd(12'h184, v);      check("R7 summary", v, 32'(1) << (8 + g));
        check("R8 irq high", 32'(irq_o), 1);
        wr(stat_of(g), 32'(1) << k);
        wr(12'h184, 32'(1) << (8 + g));
        rd(12'h184, v);      check("R7 summary clear", v, 0);
        check("R8 irq low", 32'(irq_o), 0);
        rd(stat_of(g), v);   check("R5 w1c", v, 0);
      end
    end

    // R4: high word mismatch dropped
    cap({32'h0000_0000, lo_of(2)}, 32'd1);
    idle(2);
    rd(stat_of(2), v); check("R4 mismatch", v, 0);
    check("R4 mismatch irq", 32'(irq_o), 0);

    // R6: masking keeps status, suppresses pending
    wr(12'hC08, 32'h0);
    cap({hi_of(0), lo_of(0)}, 32'd5);
    idle(2);
    rd(stat_of(0), v); check("R6 masked status", v, 32'h20);
    rd(12'h184, v);    check("R6 masked summary", v, 0);
    check("R6 masked irq", 32'(irq_o), 0);
    wr(12'hC08, 32'hFFFF_FFFF);
    idle(1);
    rd(12'h184, v);    check("R6 unmasked summary", v, 32'h100);

    // R7: clear loses to still-pending group
    wr(12'h184, 32'h100);
    idle(1);
    rd(12'h184, v);    check("R7 set wins", v, 32'h100);

    // R8: enable gating and one-cycle latency
    wr(12'h180, 32'h0);
    idle(2);
    check("R8 gated", 32'(irq_o), 0);
    wr(12'h180, 32'h0000_FF00);
    check("R8 latency low", 32'(irq_o), 0);
    idle(1);
    check("R8 latency high", 32'(irq_o), 1);
    wr(stat_of(0), 32'h20);
    wr(12'h184, 32'h100);

    // R5: capture beats same-cycle clear
    in_valid = 1'b1; in_addr = {hi_of(0), lo_of(0)}; in_data = 32'd3;
    reg_we = 1'b1; reg_addr = stat_of(0); reg_wdata = 32'h8;
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
    rd(stat_of(0), v); check("R5 capture wins", v, 32'h8);
    wr(stat_of(0), 32'h8);
    wr(12'h184, 32'h100);

    // R4: disabling one group via its enable bit
    wr(12'h190, 32'h0000_00FB);
    cap({hi_of(2), lo_of(2)}, 32'd7);
    idle(2);
    rd(stat_of(2), v); check("R4 group off", v, 0);
    check("R4 group off irq", 32'(irq_o), 0);

    // R9/R10: unmapped offsets read zero
    rd(12'h000, v); check("R10 unmapped 000", v, 0);
    rd(12'hC0C, v); check("R10 unmapped C0C", v, 0);
    rd(12'hCA0, v); check("R10 unmapped CA0", v, 0);
    rd(12'h184, v); check("R9 summary clean", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule